// File: doc/BRIEF.md
# Hiccup Fault Supervisor

This block is the digital fault supervisor of a multi-output power controller. Its inputs are single-bit, already debounced comparator results: over-current, under-voltage on the linear outputs, over-voltage on the main output, an early over-voltage sense that is valid only during power-up, and the power-on-reset condition. A digital soft-start ramp takes the place of an external capacitor. The ramp is an up/down level counter whose top value marks the end of soft-start.

When an overload occurs, the supervisor inhibits every output. It lets the soft-start level finish its climb if it has not reached the top yet, then discharges the level slowly and starts a fresh soft-start, so the converter retries in a hiccup pattern. Each hiccup is counted. The third one latches the converter off. An over-voltage skips the count: it latches off at once and forces the lower switch on. Only power-on reset clears the count and the latch.

Top module: `hiccup_supervisor`

## Requirements
- R1: With power-on reset low and no fault, the soft-start level rises by one every RISE_DIV clocks from 0 to 255, and the outputs stay enabled (inhibit low). The ramp-done flag is high exactly while the level is 255, and the level then holds at 255.
- R2: An over-current seen while the ramp is done raises inhibit on the next clock. The level then falls by one every FALL_DIV clocks. Once it reaches 0, inhibit drops and a new ramp from 0 begins.
- R3: An over-current seen while the level is still rising raises inhibit on the next clock. The level keeps rising to 255, and only then does the discharge begin.
- R4: The third counted over-current event sets the fault latch, which drives the fault output high. While the latch is set, inhibit stays high and the level discharges to 0 and stays there, until power-on reset.
- R5: The under-voltage input has no effect while the ramp-done flag is low.
- R6: While the ramp-done flag is high, an under-voltage input acts exactly like an over-current event.
- R7: An over-voltage with power-on reset low sets the fault output on the next clock without a retry, and drives the lower-switch force output high. That output stays high until power-on reset.
- R8: While power-on reset is high, the early over-voltage input drives the lower-switch force output and leaves the fault output low. While power-on reset is low, the early over-voltage input is ignored.
- R9: While power-on reset is high, the event count and the fault latch are cleared, the level is held at 0 and inhibit is high.
- R10: An event is accepted only while inhibit is low. A continuous overload is therefore counted once per hiccup, and the latch sets at the end of the third rise, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_i | input | 1 | Power-on-reset condition, active high |
| oc_i | input | 1 | Over-current comparator result |
| uv_i | input | 1 | Linear-output under-voltage comparator result |
| ov_i | input | 1 | Main-output over-voltage comparator result |
| early_ov_i | input | 1 | Over-voltage sense used during power-up |
| inhibit_o | output | 1 | Disables all outputs when high |
| ss_level_o | output | LEVEL_W | Soft-start level |
| ss_done_o | output | 1 | Soft-start level at its top value |
| low_force_o | output | 1 | Forces the lower switch on |
| fault_o | output | 1 | Fault latch state |

## Verification
The bench measures the rise and discharge times against 255 times each divider. A supervisor that discharged at once on an overload during the climb would show a falling level while inhibit is already high, and the bench catches it. A continuous overload is held through whole hiccups, and the latch-off time is checked against two full discharge-plus-rise periods. A design that counted one event per clock would latch within a few cycles. A design whose power-on reset failed to clear the count would latch after the first event of a later test. Under-voltage pulses during the climb must leave inhibit low, while an under-voltage pulse at the top must start a hiccup. An over-voltage must latch and force the lower switch within one clock, with no discharge period first.

// File: rtl/hs_pkg.sv
// Package: shared types for the hiccup supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package hs_pkg;

    // Supervisor states
    typedef enum logic [2:0] {
        ST_POR  = 3'd0,   // power-on reset held
        ST_RAMP = 3'd1,   // soft-start rising, outputs enabled
        ST_RUN  = 3'd2,   // soft-start done, normal operation
        ST_PEND = 3'd3,   // event seen during rise, finishing the climb inhibited
        ST_DIS  = 3'd4,   // discharging after a counted event
        ST_OFF  = 3'd5    // latched off
    } hs_state_e;

    // Soft-start level counter commands
    typedef enum logic [1:0] {
        SS_HOLD  = 2'd0,
        SS_UP    = 2'd1,
        SS_DOWN  = 2'd2,
        SS_CLEAR = 2'd3
    } ss_mode_e;

endpackage

// File: rtl/ss_ramp.sv
// Module: ss_ramp
// Digital soft-start level. It rises one step every RISE_DIV clocks and
// falls one step every FALL_DIV clocks, saturating at 0 and at the top.
// Assumes: RISE_DIV and FALL_DIV are at least 1; the caller picks the mode
// every cycle.
module ss_ramp
    import hs_pkg::*;
#(
    parameter int LEVEL_W  = 8,
    parameter int RISE_DIV = 4,
    parameter int FALL_DIV = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ss_mode_e           mode,
    output logic [LEVEL_W-1:0] level,
    output logic               at_top,
    output logic               at_zero
);
    localparam int DIV_MAX = (RISE_DIV > FALL_DIV) ? RISE_DIV : FALL_DIV;
    localparam int DIV_W   = (DIV_MAX < 2) ? 1 : $clog2(DIV_MAX);
    localparam logic [LEVEL_W-1:0] LEVEL_TOP  = {LEVEL_W{1'b1}};
    localparam logic [DIV_W-1:0]   RISE_LAST  = DIV_W'(RISE_DIV - 1);
    localparam logic [DIV_W-1:0]   FALL_LAST  = DIV_W'(FALL_DIV - 1);

    logic [DIV_W-1:0] div_q;

    // Level and step-divider update per mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            div_q <= '0;
        end else begin
            case (mode)
                SS_CLEAR: begin
                    level <= '0;
                    div_q <= '0;
                end
                SS_UP: begin
                    if (div_q >= RISE_LAST) begin
                        div_q <= '0;
                        if (level != LEVEL_TOP) level <= level + 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                SS_DOWN: begin
                    if (div_q >= FALL_LAST) begin
                        div_q <= '0;
                        if (level != '0) level <= level - 1'b1;
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
                default: begin
                    div_q <= '0;
                end
            endcase
        end
    end

    // Level flags
    always_comb begin
        at_top  = (level == LEVEL_TOP);
        at_zero = (level == '0);
    end

endmodule

// File: rtl/retry_counter.sv
// Module: retry_counter
// Counts accepted over-current events and holds the fault latch and the
// over-voltage latch. The clear input (power-on reset) has priority.
// Assumes: count_ev is a single-cycle pulse; RETRY_LIMIT is at least 1.
module retry_counter #(
    parameter int RETRY_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic count_ev,
    input  logic ov_set,
    output logic last_try,
    output logic fault,
    output logic ov_latched
);
    localparam int CNT_W = (RETRY_LIMIT < 2) ? 1 : $clog2(RETRY_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RETRY_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Next event reaches the limit
    always_comb last_try = (cnt_q == CNT_LAST);

    // Event counter, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (count_ev && (cnt_q != CNT_FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fault latch: set by the last retry or by over-voltage
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fault <= 1'b0;
        end else if (ov_set || (count_ev && last_try)) begin
            fault <= 1'b1;
        end
    end

    // Over-voltage latch holding the lower switch on
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ov_latched <= 1'b0;
        end else if (ov_set) begin
            ov_latched <= 1'b1;
        end
    end

endmodule

// File: rtl/hs_ctrl.sv
// Module: hs_ctrl
// Hiccup sequencing state machine. It accepts events only while the
// outputs are enabled, finishes an interrupted climb before it discharges,
// and latches off on the last retry or on over-voltage.
// Assumes: the inputs are synchronous; at_top and at_zero come from ss_ramp.
module hs_ctrl
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por,
    input  logic      oc,
    input  logic      uv,
    input  logic      ov,
    input  logic      at_top,
    input  logic      at_zero,
    input  logic      last_try,
    output ss_mode_e  mode,
    output logic      count_ev,
    output logic      ov_set,
    output logic      inhibit
);
    hs_state_e state_q, state_d;
    logic      event_now;

    // Under-voltage counts only once soft-start is complete
    always_comb event_now = oc || (uv && at_top);

    // Next state and event pulses
    always_comb begin
        state_d  = state_q;
        count_ev = 1'b0;
        ov_set   = 1'b0;
        if (por) begin
            state_d = ST_POR;
        end else if (ov) begin
            ov_set  = 1'b1;
            state_d = ST_OFF;
        end else begin
            case (state_q)
                ST_POR: state_d = ST_RAMP;
                ST_RAMP: begin
                    if (event_now && at_top) begin
                        count_ev = 1'b1;
                        state_d  = last_try ? ST_OFF : ST_DIS;
                    end else if (event_now) begin
                        state_d = ST_PEND;
                    end else if (at_top) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (event_now) begin
                        count_ev = 1'b1;
                        state_d  = last_try ? ST_OFF : ST_DIS;
                    end
                end
                ST_PEND: begin
                    if (at_top) begin
                        count_ev = 1'b1;
                        state_d  = last_try ? ST_OFF : ST_DIS;
                    end
                end
                ST_DIS: begin
                    if (at_zero) state_d = ST_RAMP;
                end
                ST_OFF:  state_d = ST_OFF;
                default: state_d = ST_POR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_POR;
        else        state_q <= state_d;
    end

    // Level command and inhibit from the current state
    always_comb begin
        inhibit = 1'b1;
        mode    = SS_CLEAR;
        if (por) begin
            mode = SS_CLEAR;
        end else begin
            case (state_q)
                ST_RAMP: begin mode = SS_UP;   inhibit = 1'b0; end
                ST_RUN:  begin mode = SS_HOLD; inhibit = 1'b0; end
                ST_PEND: mode = SS_UP;
                ST_DIS:  mode = SS_DOWN;
                ST_OFF:  mode = SS_DOWN;
                default: mode = SS_CLEAR;
            endcase
        end
    end

endmodule

// File: rtl/hiccup_supervisor.sv
// Module: hiccup_supervisor (top)
// Fault supervisor with hiccup retry, retry count and latch-off.
// Assumes: all comparator inputs are debounced and synchronous to clk.
module hiccup_supervisor
    import hs_pkg::*;
#(
    parameter int LEVEL_W     = 8,
    parameter int RISE_DIV    = 4,
    parameter int FALL_DIV    = 16,
    parameter int RETRY_LIMIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por_i,
    input  logic               oc_i,
    input  logic               uv_i,
    input  logic               ov_i,
    input  logic               early_ov_i,
    output logic               inhibit_o,
    output logic [LEVEL_W-1:0] ss_level_o,
    output logic               ss_done_o,
    output logic               low_force_o,
    output logic               fault_o
);
    ss_mode_e mode;
    logic     at_top, at_zero, last_try, count_ev, ov_set, ov_latched;

    hs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .por      (por_i),
        .oc       (oc_i),
        .uv       (uv_i),
        .ov       (ov_i),
        .at_top   (at_top),
        .at_zero  (at_zero),
        .last_try (last_try),
        .mode     (mode),
        .count_ev (count_ev),
        .ov_set   (ov_set),
        .inhibit  (inhibit_o)
    );

    ss_ramp #(
        .LEVEL_W  (LEVEL_W),
        .RISE_DIV (RISE_DIV),
        .FALL_DIV (FALL_DIV)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .level   (ss_level_o),
        .at_top  (at_top),
        .at_zero (at_zero)
    );

    retry_counter #(
        .RETRY_LIMIT (RETRY_LIMIT)
    ) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (por_i),
        .count_ev   (count_ev),
        .ov_set     (ov_set),
        .last_try   (last_try),
        .fault      (fault_o),
        .ov_latched (ov_latched)
    );

    // Output flags
    always_comb begin
        ss_done_o   = at_top;
        low_force_o = ov_latched || (por_i && early_ov_i);
    end

endmodule

// File: rtl/hiccup_supervisor_chk.sv
// Module: hiccup_supervisor_chk
// Port-level temporal checks for hiccup_supervisor, attached by bind.
module hiccup_supervisor_chk #(
    parameter int LEVEL_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               por_i,
    input logic               oc_i,
    input logic               uv_i,
    input logic               ov_i,
    input logic               early_ov_i,
    input logic               inhibit_o,
    input logic [LEVEL_W-1:0] ss_level_o,
    input logic               ss_done_o,
    input logic               low_force_o,
    input logic               fault_o
);
    // R1: the level moves by at most one step per clock outside reset
    p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_i |=> (ss_level_o == $past(ss_level_o)) ||
                   (ss_level_o == $past(ss_level_o) + 1'b1) ||
                   (ss_level_o == $past(ss_level_o) - 1'b1));

    // R4: the fault latch holds and keeps the outputs inhibited
    p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o && !por_i |=> fault_o && inhibit_o);

    // R5: under-voltage alone during the climb does not inhibit
    p_uv_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i && !ss_done_o && !oc_i && !ov_i && !por_i && !inhibit_o |=> !inhibit_o);

    // R7: over-voltage latches and forces the lower switch at once
    p_ov_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ov_i && !por_i |=> fault_o && low_force_o);

    // R7: the lower-switch force holds until power-on reset
    p_force_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_force_o && !por_i |=> low_force_o);

    // R8: early over-voltage during power-on reset forces the lower switch
    p_early_ov_r8: assert property (@(posedge clk) disable iff (!rst_n)
        por_i && early_ov_i |-> low_force_o);

    // R9: power-on reset clears the latch and the level and inhibits
    p_por_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> !fault_o && (ss_level_o == '0) && inhibit_o);

endmodule

bind hiccup_supervisor hiccup_supervisor_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_i       (por_i),
    .oc_i        (oc_i),
    .uv_i        (uv_i),
    .ov_i        (ov_i),
    .early_ov_i  (early_ov_i),
    .inhibit_o   (inhibit_o),
    .ss_level_o  (ss_level_o),
    .ss_done_o   (ss_done_o),
    .low_force_o (low_force_o),
    .fault_o     (fault_o)
);

// File: tb/hiccup_supervisor_tb_top.sv
// Bench for hiccup_supervisor using small dividers; expected times are
// computed from the level range and the dividers.
module hiccup_supervisor_tb_top;
    localparam int LW    = 8;
    localparam int RISE  = 2;
    localparam int FALL  = 3;
    localparam int TOP   = 255;
    localparam int T_UP  = TOP * RISE;
    localparam int T_DN  = TOP * FALL;
    localparam int TOL   = 4;

    logic          clk = 1'b0;
    logic          rst_n, por_i, oc_i, uv_i, ov_i, early_ov_i;
    logic          inhibit_o, ss_done_o, low_force_o, fault_o;
    logic [LW-1:0] ss_level_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    hiccup_supervisor #(
        .LEVEL_W (LW), .RISE_DIV (RISE), .FALL_DIV (FALL), .RETRY_LIMIT (3)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .por_i (por_i), .oc_i (oc_i), .uv_i (uv_i),
        .ov_i (ov_i), .early_ov_i (early_ov_i), .inhibit_o (inhibit_o),
        .ss_level_o (ss_level_o), .ss_done_o (ss_done_o),
        .low_force_o (low_force_o), .fault_o (fault_o)
    );

    always #5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // which: 0 = ramp done, 1 = level zero, 2 = fault set
    task automatic wait_for(input int which, input int limit, output int n);
        n = 0;
        while (n < limit &&
               !((which == 0 && ss_done_o) || (which == 1 && ss_level_o == 0) ||
                 (which == 2 && fault_o))) begin
            step(1);
            n++;
        end
    endtask

    task automatic por_pulse();
        por_i = 1'b1;
        step(2);
        por_i = 1'b0;
        step(1);
    endtask

    function automatic bit near(input int a, input int b);
        return (a >= b - TOL) && (a <= b + TOL);
    endfunction

    initial begin
        int  n;
        int  lvl;
        bit  bad;
        rst_n = 1'b0; por_i = 1'b1; oc_i = 1'b0; uv_i = 1'b0; ov_i = 1'b0; early_ov_i = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R9: state held by power-on reset
        check(inhibit_o == 1'b1, "R9 inhibit in por", inhibit_o, 1);
        check(ss_level_o == 0, "R9 level in por", ss_level_o, 0);
        check(fault_o == 1'b0, "R9 fault in por", fault_o, 0);
        check(ss_done_o == 1'b0, "R1 done low at reset", ss_done_o, 0);
        check(low_force_o == 1'b0, "R8 force low at reset", low_force_o, 0);

        // R8: early over-voltage during power-on reset
        early_ov_i = 1'b1;
        step(1);
        check(low_force_o == 1'b1, "R8 early ov forces", low_force_o, 1);
        check(fault_o == 1'b0, "R8 early ov no fault", fault_o, 0);
        early_ov_i = 1'b0;
        step(1);
        check(low_force_o == 1'b0, "R8 force released", low_force_o, 0);

        // R1 and R5: first ramp with under-voltage pulses during the climb
        por_i = 1'b0;
        n = 0; bad = 1'b0;
        while (!ss_done_o && n < 3 * T_UP) begin
            uv_i = (n % 50 == 10);
            step(1);
            n++;
            if (n > 2 && inhibit_o) bad = 1'b1;
        end
        uv_i = 1'b0;
        check(near(n, T_UP), "R1 ramp time", n, T_UP);
        check(!bad, "R5 uv blanked during climb", bad, 0);
        check(ss_level_o == TOP, "R1 top level", ss_level_o, TOP);
        step(20);
        check(ss_level_o == TOP && !inhibit_o, "R1 hold at top", ss_level_o, TOP);

        // R2: over-current at the top
        oc_i = 1'b1; step(1); oc_i = 1'b0;
        check(inhibit_o == 1'b1, "R2 inhibit after oc", inhibit_o, 1);
        wait_for(1, 3 * T_DN, n);
        check(near(n, T_DN), "R2 discharge time", n, T_DN);
        step(2);
        check(inhibit_o == 1'b0, "R2 inhibit released", inhibit_o, 0);
        wait_for(0, 3 * T_UP, n);

        // R6: under-voltage at the top acts as an event
        uv_i = 1'b1; step(1); uv_i = 1'b0;
        check(inhibit_o == 1'b1, "R6 uv at top inhibits", inhibit_o, 1);
        wait_for(1, 3 * T_DN, n);
        check(fault_o == 1'b0, "R6 no fault after two events", fault_o, 0);

        // R9: clear the count, then R3 with an event during the climb
        por_pulse();
        check(fault_o == 1'b0, "R9 fault after por", fault_o, 0);
        step(200);
        oc_i = 1'b1; step(1); oc_i = 1'b0;
        check(inhibit_o == 1'b1, "R3 inhibit during climb", inhibit_o, 1);
        lvl = ss_level_o;
        step(10);
        check(ss_level_o > lvl, "R3 level still rising", ss_level_o, lvl + 5);
        wait_for(0, 3 * T_UP, n);
        check(ss_done_o && inhibit_o, "R3 reaches top inhibited", ss_level_o, TOP);
        wait_for(1, 3 * T_DN, n);
        check(near(n, T_DN), "R3 discharge after top", n, T_DN);
        check(fault_o == 1'b0, "R9 count cleared by por", fault_o, 0);

        // R10 and R4: continuous overload from a fresh start
        por_pulse();
        wait_for(0, 3 * T_UP, n);
        oc_i = 1'b1;
        step(2 * T_DN + T_UP);
        check(fault_o == 1'b0, "R10 no early latch", fault_o, 0);
        wait_for(2, 3 * T_UP, n);
        check(near(n + 2 * T_DN + T_UP, 2 * T_DN + 2 * T_UP), "R10 latch time",
              n + 2 * T_DN + T_UP, 2 * T_DN + 2 * T_UP);
        check(fault_o == 1'b1, "R4 fault set", fault_o, 1);
        oc_i = 1'b0;
        step(T_DN + 20);
        check(ss_level_o == 0, "R4 level discharged", ss_level_o, 0);
        check(inhibit_o == 1'b1 && fault_o == 1'b1, "R4 stays off", fault_o, 1);
        check(low_force_o == 1'b0, "R4 no switch force", low_force_o, 0);
        por_pulse();
        check(fault_o == 1'b0, "R9 por clears latch", fault_o, 0);

        // R7: over-voltage latches at once
        wait_for(0, 3 * T_UP, n);
        ov_i = 1'b1; step(1); ov_i = 1'b0;
        check(fault_o == 1'b1, "R7 fault next clock", fault_o, 1);
        check(low_force_o == 1'b1, "R7 switch forced", low_force_o, 1);
        step(5);
        check(low_force_o && inhibit_o, "R7 force held", low_force_o, 1);
        por_pulse();
        check(low_force_o == 1'b0 && fault_o == 1'b0, "R7 released by por", low_force_o, 0);

        // R8: early over-voltage ignored outside power-on reset
        early_ov_i = 1'b1; step(1);
        check(low_force_o == 1'b0, "R8 ignored without por", low_force_o, 0);
        early_ov_i = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule